// File: doc/BRIEF.md
# FIFO Threshold Interrupt Unit

This block is the status and interrupt logic that sits around a pair of fixed-depth transmit and receive FIFOs. The FIFO storage and the serial shifter are outside it. Two sources drive it. The bus side writes the data register to push a transmit frame and reads it to pop a receive frame. The serial side takes transmit frames and delivers receive frames. From these strobes the block keeps an entry count for each FIFO. It compares each count with a threshold that software can program, and it latches error conditions.

The block has five interrupt sources: transmit-empty, transmit-overflow, receive-underflow, receive-overflow and receive-full. Their raw flags pass through a per-source enable mask. The result is a masked status word and one combined interrupt line. The threshold registers accept only values below the FIFO depth. Software can therefore find the depth by writing candidate values and reading them back. A read of the clear register drops the latched error flags.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset both levels, both thresholds and the mask are zero, the latched error flags are clear and irq_o is low. The raw status therefore reads 0x01, because transmit-empty holds at level 0 with threshold 0.
- R2: Address 0x3 returns the transmit entry count and address 0x4 returns the receive entry count. The transmit count rises on each accepted write to address 0x0 and falls on each accepted tx_pop_i. The receive count rises on each accepted rx_push_i and falls on each accepted read of address 0x0. A push while the FIFO is full is rejected and leaves the count unchanged.
- R3: Raw bit 0 (transmit-empty) is 1 exactly when the transmit level is at or below the transmit threshold (address 0x1).
- R4: Raw bit 4 (receive-full) is 1 exactly when the receive level exceeds the receive threshold (address 0x2). A threshold of N-1 therefore fires at N entries.
- R5: A write to address 0x0 while the transmit level equals DEPTH sets raw bit 1 (transmit-overflow). The frame is discarded.
- R6: A read of address 0x0 while the receive level is 0 sets raw bit 2 (receive-underflow). The level stays at 0.
- R7: An rx_push_i while the receive level equals DEPTH sets raw bit 3 (receive-overflow). The frame is discarded.
- R8: Raw bits 1 to 3 stay set until a read of address 0x8 or until en_i goes low. The address 0x8 read returns those bits at their positions before they clear. A new error in the same cycle as the clear leaves its flag set.
- R9: A threshold write with a value of DEPTH or more is not retained, and the register keeps its previous value.
- R10: The masked status at address 0x7 is the raw status at address 0x6 ANDed with the mask at address 0x5 (bit n enables source n). irq_o is high when any masked bit is set.
- R11: While en_i is low, both levels are held at zero and all push and pop strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low flushes levels and clears errors |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tx_pop_i | input | 1 | Serial side took a transmit frame |
| rx_push_i | input | 1 | Serial side delivered a receive frame |
| tx_push_o | output | 1 | Transmit push accepted, write storage |
| rx_pop_o | output | 1 | Receive pop accepted, advance storage |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench drives both FIFOs to exactly DEPTH entries and then pushes once more. A design that compared against DEPTH-1, or that kept counting, would report a wrong level or miss the overflow flag. It walks both threshold comparisons across their boundaries: transmit-empty is "at or below" and receive-full is "strictly above". An off-by-one design flips the flag one entry early or late. It writes threshold values of DEPTH and above and reads them back. A design that truncates such a value instead of ignoring it would read back a different number. It checks that the clear read returns the errors and then drops them, and that dropping enable flushes both levels and ignores a write made while disabled.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam int AW      = 4;
  localparam int NIRQ    = 5;

  localparam logic [AW-1:0] A_DATA  = 4'h0;
  localparam logic [AW-1:0] A_TXTHR = 4'h1;
  localparam logic [AW-1:0] A_RXTHR = 4'h2;
  localparam logic [AW-1:0] A_TXLVL = 4'h3;
  localparam logic [AW-1:0] A_RXLVL = 4'h4;
  localparam logic [AW-1:0] A_MASK  = 4'h5;
  localparam logic [AW-1:0] A_RAW   = 4'h6;
  localparam logic [AW-1:0] A_STAT  = 4'h7;
  localparam logic [AW-1:0] A_CLR   = 4'h8;

  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;
endpackage

// File: rtl/fti_level_ctr.sv
module fti_level_ctr #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [LW-1:0] lvl_o,
  output logic          push_ok_o,
  output logic          push_rej_o,
  output logic          pop_ok_o,
  output logic          pop_rej_o
);
  logic full, empty;

  assign full       = (lvl_o == LW'(DEPTH));
  assign empty      = (lvl_o == '0);
  assign push_ok_o  = push_i & ~full;
  assign push_rej_o = push_i & full;
  assign pop_ok_o   = pop_i & ~empty;
  assign pop_rej_o  = pop_i & empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_o <= '0;
    else if (flush_i) lvl_o <= '0;
    else              lvl_o <= lvl_o + LW'(push_ok_o) - LW'(pop_ok_o);
  end

  a_r2_lvl_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o <= LW'(DEPTH));
  a_r2_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !flush_i) |=> $stable(lvl_o));
  a_r2_empty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && pop_i && !push_i) |=> (lvl_o == '0));
endmodule

// File: rtl/fti_sticky.sv
module fti_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/fti_thr_reg.sv
module fti_thr_reg #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [TW-1:0] q_o
);
  logic in_range;
  assign in_range = (wdata_i < DW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (wr_i && in_range)  q_o <= wdata_i[TW-1:0];
  end

  a_r9_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !in_range) |=> $stable(q_o));
  a_r9_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    DW'(q_o) < DW'(DEPTH));
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fti_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          tx_pop_i,
  input  logic          rx_push_i,
  output logic          tx_push_o,
  output logic          rx_pop_o,
  output logic          irq_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);
  localparam int NERR = 3;

  logic [LW-1:0]   tx_lvl, rx_lvl;
  logic [TW-1:0]   tx_thr, rx_thr;
  logic [NIRQ-1:0] mask_q, raw, stat;
  logic            data_wr, data_rd, clr_rd, err_clr;
  logic            tx_rej, tx_pop_rej, rx_push_rej, rx_pop_rej;
  logic [NERR-1:0] err_set, err_q;

  assign data_wr = reg_wr_i & en_i & (reg_addr_i == A_DATA);
  assign data_rd = reg_rd_i & en_i & (reg_addr_i == A_DATA);
  assign clr_rd  = reg_rd_i & (reg_addr_i == A_CLR);
  assign err_clr = clr_rd | ~en_i;

  fti_level_ctr #(.DEPTH(DEPTH)) u_tx_ctr (
    .clk_i, .rst_ni, .flush_i(~en_i),
    .push_i(data_wr), .pop_i(tx_pop_i & en_i),
    .lvl_o(tx_lvl), .push_ok_o(tx_push_o), .push_rej_o(tx_rej),
    .pop_ok_o(), .pop_rej_o(tx_pop_rej));

  fti_level_ctr #(.DEPTH(DEPTH)) u_rx_ctr (
    .clk_i, .rst_ni, .flush_i(~en_i),
    .push_i(rx_push_i & en_i), .pop_i(data_rd),
    .lvl_o(rx_lvl), .push_ok_o(), .push_rej_o(rx_push_rej),
    .pop_ok_o(rx_pop_o), .pop_rej_o(rx_pop_rej));

  fti_thr_reg #(.DEPTH(DEPTH), .DW(DW)) u_tx_thr (
    .clk_i, .rst_ni, .wr_i(reg_wr_i && reg_addr_i == A_TXTHR),
    .wdata_i(reg_wdata_i), .q_o(tx_thr));

  fti_thr_reg #(.DEPTH(DEPTH), .DW(DW)) u_rx_thr (
    .clk_i, .rst_ni, .wr_i(reg_wr_i && reg_addr_i == A_RXTHR),
    .wdata_i(reg_wdata_i), .q_o(rx_thr));

  // error sources in raw-bit order B_TXO..B_RXO
  assign err_set = {rx_push_rej, rx_pop_rej, tx_rej};

  for (genvar g = 0; g < NERR; g++) begin : g_err
    fti_sticky u_flag (
      .clk_i, .rst_ni, .set_i(err_set[g]), .clr_i(err_clr), .q_o(err_q[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              mask_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[NIRQ-1:0];
  end

  always_comb begin
    raw        = '0;
    raw[B_TXE] = (tx_lvl <= LW'(tx_thr));
    raw[B_RXF] = (rx_lvl > LW'(rx_thr));
    raw[B_RXO:B_TXO] = err_q;
  end

  assign stat  = raw & mask_q;
  assign irq_o = |stat;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_TXTHR: reg_rdata_o = DW'(tx_thr);
      A_RXTHR: reg_rdata_o = DW'(rx_thr);
      A_TXLVL: reg_rdata_o = DW'(tx_lvl);
      A_RXLVL: reg_rdata_o = DW'(rx_lvl);
      A_MASK:  reg_rdata_o = DW'(mask_q);
      A_RAW:   reg_rdata_o = DW'(raw);
      A_STAT:  reg_rdata_o = DW'(stat);
      A_CLR:   reg_rdata_o = DW'({err_q, 1'b0});
      default: reg_rdata_o = '0;
    endcase
  end

  a_r10_masked_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  a_r5_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && tx_lvl == LW'(DEPTH)) |=> raw[B_TXO]);
  a_r7_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rx_push_i && rx_lvl == LW'(DEPTH)) |=> raw[B_RXO]);
  a_r11_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tx_lvl == '0 && rx_lvl == '0));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr && err_set == '0) |=> (err_q == '0));
endmodule

// File: tb/fifo_irq_unit_tb_top.sv
module fifo_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 0, rst_ni = 0, en_i = 0;
  logic        reg_wr_i = 0, reg_rd_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic        tx_pop_i = 0, rx_push_i = 0;
  logic        tx_push_o, rx_pop_o, irq_o;

  int total = 0, bad = 0;
  logic chk_v = 0;
  int   exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_irq_unit #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni, .en_i, .reg_wr_i, .reg_rd_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .tx_pop_i, .rx_push_i,
    .tx_push_o, .rx_pop_o, .irq_o);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against scoreboard
  always @(negedge clk) begin
    if (chk_v && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(reg_rdata_o == 32'(e), t, int'(reg_rdata_o), e);
    end
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(posedge clk); #1;
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = 32'(d);
    @(posedge clk); #1;
    reg_wr_i = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input int e, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd_i = 1; reg_addr_i = a; chk_v = 1;
    @(posedge clk); #1;
    reg_rd_i = 0; chk_v = 0;
  endtask

  task automatic data_rd();
    @(posedge clk); #1;
    reg_rd_i = 1; reg_addr_i = 4'h0;
    @(posedge clk); #1;
    reg_rd_i = 0;
  endtask

  task automatic pulse_tx_pop();
    @(posedge clk); #1; tx_pop_i = 1;
    @(posedge clk); #1; tx_pop_i = 0;
  endtask

  task automatic pulse_rx_push();
    @(posedge clk); #1; rx_push_i = 1;
    @(posedge clk); #1; rx_push_i = 0;
  endtask

  task automatic check_irq(input bit e, input string tag);
    @(negedge clk);
    check(irq_o == e, tag, int'(irq_o), int'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1; en_i = 1;
    // R1 reset state
    rd_chk(4'h3, 0, "R1 tx level");
    rd_chk(4'h4, 0, "R1 rx level");
    rd_chk(4'h1, 0, "R1 tx thr");
    rd_chk(4'h5, 0, "R1 mask");
    rd_chk(4'h6, 32'h01, "R1 raw");
    check_irq(0, "R1 irq");
    // R9 threshold retention
    wr(4'h1, DEPTH);     rd_chk(4'h1, 0, "R9 tx thr depth ignored");
    wr(4'h1, 3);         rd_chk(4'h1, 3, "R9 tx thr accepted");
    wr(4'h1, DEPTH + 1); rd_chk(4'h1, 3, "R9 tx thr kept");
    wr(4'h2, 2);         rd_chk(4'h2, 2, "R9 rx thr accepted");
    wr(4'h2, 15);        rd_chk(4'h2, 2, "R9 rx thr kept");
    // R3 transmit-empty boundary
    for (int i = 0; i < 4; i++) wr(4'h0, i);
    rd_chk(4'h3, 4, "R2 tx level 4");
    rd_chk(4'h6, 32'h00, "R3 level above thr");
    pulse_tx_pop();
    rd_chk(4'h6, 32'h01, "R3 level at thr");
    // R5 transmit overflow
    for (int i = 0; i < 5; i++) wr(4'h0, i);
    rd_chk(4'h3, DEPTH, "R2 tx full");
    wr(4'h0, 99);
    rd_chk(4'h3, DEPTH, "R5 level unchanged");
    rd_chk(4'h6, 32'h02, "R5 ovf flag");
    // R4 receive-full boundary
    pulse_rx_push(); pulse_rx_push();
    rd_chk(4'h6, 32'h02, "R4 level at thr");
    pulse_rx_push();
    rd_chk(4'h6, 32'h12, "R4 level above thr");
    // R7 receive overflow
    for (int i = 0; i < 5; i++) pulse_rx_push();
    rd_chk(4'h4, DEPTH, "R2 rx full");
    pulse_rx_push();
    rd_chk(4'h4, DEPTH, "R7 level unchanged");
    rd_chk(4'h6, 32'h1A, "R7 ovf flag");
    // R10 mask
    wr(4'h5, 32'h08);
    rd_chk(4'h7, 32'h08, "R10 masked status");
    check_irq(1, "R10 irq on");
    wr(4'h5, 32'h01);
    rd_chk(4'h7, 32'h00, "R10 masked off");
    check_irq(0, "R10 irq off");
    // R8 clear on read
    rd_chk(4'h6, 32'h1A, "R8 still latched");
    rd_chk(4'h8, 32'h0A, "R8 clear returns errors");
    rd_chk(4'h6, 32'h10, "R8 errors cleared");
    // R6 receive underflow
    for (int i = 0; i < DEPTH; i++) data_rd();
    rd_chk(4'h4, 0, "R2 rx drained");
    data_rd();
    rd_chk(4'h4, 0, "R6 level stays 0");
    rd_chk(4'h6, 32'h04, "R6 udf flag");
    wr(4'h5, 32'h04);
    check_irq(1, "R10 irq udf");
    // R11 disable
    @(posedge clk); #1 en_i = 0;
    wr(4'h0, 5);
    @(posedge clk); #1 en_i = 1;
    rd_chk(4'h3, 0, "R11 tx flushed, write ignored");
    rd_chk(4'h4, 0, "R11 rx flushed");
    rd_chk(4'h6, 32'h01, "R11 errors cleared");
    check_irq(0, "R11 irq low");
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule